// File: doc/BRIEF.md
# Dual quad-SPI flash connection router

This block sits between a quad-SPI command engine that knows about one flash device and the pins of two identical flash devices. The engine supplies one logical chip select, a serial clock level, a drive enable and outgoing data. It also takes read data back. The router turns these into two physical buses, each with its own chip select, clock, four data lanes and lane enables. A configuration word picks one of three routings: a single device, two devices stacked on one shared bus, or two devices in parallel on separate buses.

In stacked mode a page bit chooses which device's chip select is driven. Data and clock stay on the lower bus, which both devices share. In parallel mode both chip selects assert together. Each engine byte is split so that its even-numbered bits travel on the lower bus and its odd-numbered bits travel on the upper bus. Read nibbles from the two buses are re-interleaved into one byte. The routing is latched only while both physical chip selects are idle, so a configuration write never disturbs a transfer in flight.

Top module: `qspi_dual_router`

## Requirements
- R1: While `rst` is high and in the first cycle after it, both chip selects are high (idle), both clocks are low, all lane enables are zero and `eng_din` is zero.
- R2: With configuration bit 30 clear the route is single-device, and bits 29 and 28 have no effect. The lower chip select follows `eng_cs_n`, `up_cs_n` stays high, and `eng_dout[3:0]` drives lanes 3..0 of the lower bus.
- R3: With bit 30 set, bit 29 clear and bit 28 clear (stacked, lower page), only `lo_cs_n` follows `eng_cs_n`. `up_cs_n` stays high and data goes out on the lower bus.
- R4: With bit 30 set, bit 29 clear and bit 28 set (stacked, upper page), only `up_cs_n` follows `eng_cs_n`. `lo_cs_n` stays high, and data and clock still go out on the lower bus.
- R5: With bits 30 and 29 both set (parallel), both chip selects follow `eng_cs_n` together and both clocks follow `eng_sclk`.
- R6: In parallel mode, lower-bus lane i carries `eng_dout` bit 2i and upper-bus lane i carries bit 2i+1, for i = 0..3.
- R7: In parallel mode, `eng_din` bit 2i is taken from `lo_dq_i[i]` and bit 2i+1 from `up_dq_i[i]`. A write followed by a read of the same positions returns the original bytes.
- R8: Outside parallel mode, `eng_din` is `lo_dq_i` in bits 3..0 with bits 7..4 zero, whichever device is selected.
- R9: `lo_dq_oe` has all four bits equal to `eng_oe`. Outside parallel mode, `up_dq_oe` stays zero, `up_sclk` stays low and `up_dq_o` stays zero.
- R10: The configuration is captured only in cycles where `eng_cs_n` is high and both physical chip selects are high. A change made during a transfer takes effect only at the next chip-select assertion.
- R11: Every output is registered and reflects the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration: bit 30 two devices, bit 29 separate buses, bit 28 upper page |
| eng_cs_n | input | 1 | Engine logical chip select, active low |
| eng_sclk | input | 1 | Engine serial clock level |
| eng_oe | input | 1 | Engine drive enable for the data lanes |
| eng_dout | input | 8 | Engine outgoing data (bits 3..0 only outside parallel mode) |
| eng_din | output | 8 | Read data returned to the engine |
| lo_cs_n | output | 1 | Lower device chip select, active low |
| lo_sclk | output | 1 | Lower (shared) bus clock |
| lo_dq_o | output | 4 | Lower bus outgoing lanes |
| lo_dq_oe | output | 4 | Lower bus lane enables |
| lo_dq_i | input | 4 | Lower bus incoming lanes |
| up_cs_n | output | 1 | Upper device chip select, active low |
| up_sclk | output | 1 | Upper bus clock (parallel mode only) |
| up_dq_o | output | 4 | Upper bus outgoing lanes |
| up_dq_oe | output | 4 | Upper bus lane enables |
| up_dq_i | input | 4 | Upper bus incoming lanes |

## Verification
A corrupted route shows up as the wrong chip select going low in the first cycle after the engine asserts its select. It also leaves data in the device that should not have been touched, which the bench sees by inspecting both device models after every write. A wrong lane order in the split or the merge does not show with all-zero or all-one data. It shows within one byte of the alternating patterns 55 and AA, and a readback reveals it at once. A latch that updates during a transfer moves the chip select mid-burst, and the last recorded select state of that same transfer exposes it.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  typedef enum logic [1:0] {
    QDR_SINGLE   = 2'd0,
    QDR_STACK_LO = 2'd1,
    QDR_STACK_UP = 2'd2,
    QDR_PARALLEL = 2'd3
  } qdr_route_e;
endpackage

// File: rtl/qdr_mode_latch.sv
module qdr_mode_latch
  import qdr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int DUAL_BIT = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             eng_cs_n,
  input  logic             bus_idle,
  output qdr_route_e       route
);
  logic       unused_cfg;
  qdr_route_e route_d;

  assign unused_cfg = ^cfg_word;

  always_comb begin
    if (!cfg_word[DUAL_BIT])     route_d = QDR_SINGLE;
    else if (cfg_word[SEP_BIT])  route_d = QDR_PARALLEL;
    else if (cfg_word[PAGE_BIT]) route_d = QDR_STACK_UP;
    else                         route_d = QDR_STACK_LO;
  end

  always_ff @(posedge clk) begin
    if (rst)                       route <= QDR_SINGLE;
    else if (eng_cs_n && bus_idle) route <= route_d;
  end

  // R10
  route_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_idle |=> $stable(route));
endmodule

// File: rtl/qdr_lane_split.sv
module qdr_lane_split #(
  parameter int LANES = 4
) (
  input  logic [2*LANES-1:0] byte_i,
  output logic [LANES-1:0]   even_o,
  output logic [LANES-1:0]   odd_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign even_o[i] = byte_i[2*i];
    assign odd_o[i]  = byte_i[2*i+1];
  end
endmodule

// File: rtl/qdr_lane_merge.sv
module qdr_lane_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   even_i,
  input  logic [LANES-1:0]   odd_i,
  output logic [2*LANES-1:0] byte_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign byte_o[2*i]   = even_i[i];
    assign byte_o[2*i+1] = odd_i[i];
  end
endmodule

// File: rtl/qspi_dual_router.sv
module qspi_dual_router
  import qdr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int DUAL_BIT = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28,
  parameter int LANES    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic               eng_cs_n,
  input  logic               eng_sclk,
  input  logic               eng_oe,
  input  logic [2*LANES-1:0] eng_dout,
  output logic [2*LANES-1:0] eng_din,
  output logic               lo_cs_n,
  output logic               lo_sclk,
  output logic [LANES-1:0]   lo_dq_o,
  output logic [LANES-1:0]   lo_dq_oe,
  input  logic [LANES-1:0]   lo_dq_i,
  output logic               up_cs_n,
  output logic               up_sclk,
  output logic [LANES-1:0]   up_dq_o,
  output logic [LANES-1:0]   up_dq_oe,
  input  logic [LANES-1:0]   up_dq_i
);
  localparam int BYTE_W = 2 * LANES;

  qdr_route_e        route;
  logic              bus_idle;
  logic              par;
  logic [LANES-1:0]  split_even, split_odd;
  logic [BYTE_W-1:0] merged;

  assign bus_idle = lo_cs_n & up_cs_n;
  assign par      = (route == QDR_PARALLEL);

  qdr_mode_latch #(
    .CFG_W(CFG_W), .DUAL_BIT(DUAL_BIT), .SEP_BIT(SEP_BIT), .PAGE_BIT(PAGE_BIT)
  ) mode_i (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .eng_cs_n(eng_cs_n),
    .bus_idle(bus_idle), .route(route)
  );

  qdr_lane_split #(.LANES(LANES)) split_i (
    .byte_i(eng_dout), .even_o(split_even), .odd_o(split_odd)
  );

  qdr_lane_merge #(.LANES(LANES)) merge_i (
    .even_i(lo_dq_i), .odd_i(up_dq_i), .byte_o(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cs_n  <= 1'b1;
      up_cs_n  <= 1'b1;
      lo_sclk  <= 1'b0;
      up_sclk  <= 1'b0;
      lo_dq_o  <= '0;
      up_dq_o  <= '0;
      lo_dq_oe <= '0;
      up_dq_oe <= '0;
      eng_din  <= '0;
    end else begin
      lo_cs_n  <= eng_cs_n | (route == QDR_STACK_UP);
      up_cs_n  <= eng_cs_n | (route == QDR_SINGLE) | (route == QDR_STACK_LO);
      lo_sclk  <= eng_sclk;
      up_sclk  <= eng_sclk & par;
      lo_dq_o  <= par ? split_even : eng_dout[LANES-1:0];
      up_dq_o  <= par ? split_odd : '0;
      lo_dq_oe <= {LANES{eng_oe}};
      up_dq_oe <= {LANES{eng_oe & par}};
      eng_din  <= par ? merged : {{LANES{1'b0}}, lo_dq_i};
    end
  end

  // R5
  dual_cs_par_chk: assert property (@(posedge clk) disable iff (rst)
    (!lo_cs_n && !up_cs_n) |-> (route == QDR_PARALLEL));

  // R2
  up_cs_dual_chk: assert property (@(posedge clk) disable iff (rst)
    !up_cs_n |-> (route != QDR_SINGLE));

  // R11
  cs_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(eng_cs_n) |-> (lo_cs_n && up_cs_n));

  // R9
  up_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((route != QDR_PARALLEL) && $stable(route)) |-> (up_dq_oe == '0 && !up_sclk));
endmodule

// File: tb/qspi_dual_router_tb_top.sv
module qdr_flash_model (
  input  logic       clk,
  input  logic       clr,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       oe,
  input  logic [3:0] dq,
  output logic [3:0] q,
  output logic       drive
);
  logic [3:0] mem [64];
  logic [5:0] ptr;
  logic       sclk_prev;

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 4'h0;
    ptr = '0;
    sclk_prev = 1'b0;
  end

  assign q     = mem[ptr];
  assign drive = !cs_n && !oe;

  always @(negedge clk) begin
    if (clr) begin
      for (int k = 0; k < 64; k++) mem[k] <= 4'h0;
    end else if (!cs_n && sclk && !sclk_prev && oe) begin
      mem[ptr] <= dq;
    end
    if (cs_n) ptr <= '0;
    else if (sclk && !sclk_prev) ptr <= ptr + 6'd1;
    sclk_prev <= sclk;
  end
endmodule

module qspi_dual_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = 32'h0;
  logic        eng_cs_n = 1'b1, eng_sclk = 1'b0, eng_oe = 1'b0;
  logic [7:0]  eng_dout = 8'h0;
  logic [7:0]  eng_din;
  logic        lo_cs_n, lo_sclk, up_cs_n, up_sclk;
  logic [3:0]  lo_dq_o, lo_dq_oe, lo_dq_i, up_dq_o, up_dq_oe, up_dq_i;

  logic        board_par = 1'b0;
  logic        clr = 1'b0;
  logic [3:0]  lo_q, up_q;
  logic        lo_drive, up_drive;

  int          checks = 0;
  int          errors = 0;
  logic [7:0]  tx [32];
  logic [7:0]  rx [32];
  logic        last_lo_cs, last_up_cs, up_activity;

  always #4 clk = ~clk;

  qspi_dual_router dut_i (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .eng_cs_n(eng_cs_n),
    .eng_sclk(eng_sclk), .eng_oe(eng_oe), .eng_dout(eng_dout), .eng_din(eng_din),
    .lo_cs_n(lo_cs_n), .lo_sclk(lo_sclk), .lo_dq_o(lo_dq_o), .lo_dq_oe(lo_dq_oe),
    .lo_dq_i(lo_dq_i), .up_cs_n(up_cs_n), .up_sclk(up_sclk), .up_dq_o(up_dq_o),
    .up_dq_oe(up_dq_oe), .up_dq_i(up_dq_i)
  );

  qdr_flash_model dev_lo (
    .clk(clk), .clr(clr), .cs_n(lo_cs_n), .sclk(lo_sclk), .oe(lo_dq_oe[0]),
    .dq(lo_dq_o), .q(lo_q), .drive(lo_drive)
  );

  qdr_flash_model dev_up (
    .clk(clk), .clr(clr), .cs_n(up_cs_n),
    .sclk(board_par ? up_sclk : lo_sclk),
    .oe(board_par ? up_dq_oe[0] : lo_dq_oe[0]),
    .dq(board_par ? up_dq_o : lo_dq_o), .q(up_q), .drive(up_drive)
  );

  assign lo_dq_i = lo_drive ? lo_q : ((!board_par && up_drive) ? up_q : 4'h0);
  assign up_dq_i = (board_par && up_drive) ? up_q : 4'h0;

  function automatic logic [3:0] even_of(input logic [7:0] b);
    return {b[6], b[4], b[2], b[0]};
  endfunction

  function automatic logic [3:0] odd_of(input logic [7:0] b);
    return {b[7], b[5], b[3], b[1]};
  endfunction

  function automatic logic [31:0] mk_cfg(input bit dual, input bit sep, input bit page);
    logic [31:0] v;
    v = $urandom & 32'h8FFF_FFFF;
    v[30] = dual; v[29] = sep; v[28] = page;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_devs();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic fill_tx(input int n);
    for (int k = 0; k < n; k++) tx[k] = 8'($urandom);
    tx[0] = 8'h55; tx[1] = 8'hAA; tx[2] = 8'h00; tx[3] = 8'hFF;
  endtask

  task automatic xfer(input int n, input bit wr, input bit mid, input logic [31:0] mid_cfg);
    up_activity = 1'b0;
    @(negedge clk);
    eng_cs_n = 1'b0;
    eng_oe   = wr;
    for (int k = 0; k < n; k++) begin
      eng_sclk = 1'b0;
      eng_dout = tx[k];
      if (mid && k == 1) cfg_word = mid_cfg;
      @(negedge clk);
      up_activity |= up_sclk | (|up_dq_oe);
      eng_sclk = 1'b1;
      @(negedge clk);
      up_activity |= up_sclk | (|up_dq_oe);
      rx[k] = eng_din;
      last_lo_cs = lo_cs_n;
      last_up_cs = up_cs_n;
    end
    eng_sclk = 1'b0;
    eng_oe   = 1'b0;
    @(negedge clk);
    eng_cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int bad;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1: during reset
    chk("R1 cs during reset", {30'd0, lo_cs_n, up_cs_n}, 32'd3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cs idle", {30'd0, lo_cs_n, up_cs_n}, 32'd3);
    chk("R1 clocks low", {30'd0, lo_sclk, up_sclk}, 32'd0);
    chk("R1 enables zero", {24'd0, lo_dq_oe, up_dq_oe}, 32'd0);
    chk("R1 din zero", {24'd0, eng_din}, 32'd0);

    // R2: single device, bits 29 and 28 set but ignored
    cfg_word = mk_cfg(1'b0, 1'b1, 1'b1);
    board_par = 1'b0;
    fill_tx(16);
    repeat (2) @(negedge clk);
    xfer(16, 1'b1, 1'b0, 32'h0);
    chk("R2 cs pattern", {30'd0, last_lo_cs, last_up_cs}, 32'd1);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      if (dev_lo.mem[k] !== tx[k][3:0]) bad++;
      if (dev_up.mem[k] !== 4'h0) bad++;
    end
    chk("R2 single write placement", bad, 0);
    chk("R9 upper bus idle single", {31'd0, up_activity}, 32'd0);
    xfer(16, 1'b0, 1'b0, 32'h0);
    bad = 0;
    for (int k = 0; k < 16; k++) if (rx[k] !== {4'h0, tx[k][3:0]}) bad++;
    chk("R8 single readback", bad, 0);

    // R3: stacked, lower page
    clear_devs();
    cfg_word = mk_cfg(1'b1, 1'b0, 1'b0);
    fill_tx(8);
    repeat (2) @(negedge clk);
    xfer(8, 1'b1, 1'b0, 32'h0);
    chk("R3 cs pattern", {30'd0, last_lo_cs, last_up_cs}, 32'd1);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      if (dev_lo.mem[k] !== tx[k][3:0]) bad++;
      if (dev_up.mem[k] !== 4'h0) bad++;
    end
    chk("R3 stacked lower placement", bad, 0);

    // R4: stacked, upper page
    clear_devs();
    cfg_word = mk_cfg(1'b1, 1'b0, 1'b1);
    fill_tx(8);
    repeat (2) @(negedge clk);
    xfer(8, 1'b1, 1'b0, 32'h0);
    chk("R4 cs pattern", {30'd0, last_lo_cs, last_up_cs}, 32'd2);
    chk("R9 upper bus idle stacked", {31'd0, up_activity}, 32'd0);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      if (dev_up.mem[k] !== tx[k][3:0]) bad++;
      if (dev_lo.mem[k] !== 4'h0) bad++;
    end
    chk("R4 stacked upper placement", bad, 0);
    xfer(8, 1'b0, 1'b0, 32'h0);
    bad = 0;
    for (int k = 0; k < 8; k++) if (rx[k] !== {4'h0, tx[k][3:0]}) bad++;
    chk("R8 stacked upper readback", bad, 0);

    // R5 R6: parallel write
    clear_devs();
    cfg_word = mk_cfg(1'b1, 1'b1, $urandom_range(0, 1) == 1);
    board_par = 1'b1;
    fill_tx(16);
    repeat (2) @(negedge clk);
    xfer(16, 1'b1, 1'b0, 32'h0);
    chk("R5 both cs low", {30'd0, last_lo_cs, last_up_cs}, 32'd0);
    chk("R9 upper enables in parallel", {31'd0, up_activity}, 32'd1);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      if (dev_lo.mem[k] !== even_of(tx[k])) bad++;
      if (dev_up.mem[k] !== odd_of(tx[k])) bad++;
    end
    chk("R6 even/odd split", bad, 0);
    chk("R6 pattern 55 lower", {28'd0, dev_lo.mem[0]}, 32'hF);
    chk("R6 pattern AA upper", {28'd0, dev_up.mem[1]}, 32'hF);
    // R7: parallel readback
    xfer(16, 1'b0, 1'b0, 32'h0);
    bad = 0;
    for (int k = 0; k < 16; k++) if (rx[k] !== tx[k]) bad++;
    chk("R7 parallel readback", bad, 0);
    chk("R7 byte AA", {24'd0, rx[1]}, 32'hAA);

    // R11: one-cycle latency on chip select
    @(negedge clk);
    eng_cs_n = 1'b0;
    #1;
    chk("R11 cs before edge", {30'd0, lo_cs_n, up_cs_n}, 32'd3);
    @(negedge clk);
    chk("R11 cs after edge", {30'd0, lo_cs_n, up_cs_n}, 32'd0);
    eng_cs_n = 1'b1;
    @(negedge clk);
    chk("R11 cs release", {30'd0, lo_cs_n, up_cs_n}, 32'd3);
    repeat (2) @(negedge clk);

    // R10: configuration change mid-transfer
    clear_devs();
    board_par = 1'b0;
    cfg_word = mk_cfg(1'b1, 1'b0, 1'b0);
    fill_tx(8);
    repeat (2) @(negedge clk);
    xfer(8, 1'b1, 1'b1, mk_cfg(1'b1, 1'b0, 1'b1));
    chk("R10 cs held across change", {30'd0, last_lo_cs, last_up_cs}, 32'd1);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      if (dev_lo.mem[k] !== tx[k][3:0]) bad++;
      if (dev_up.mem[k] !== 4'h0) bad++;
    end
    chk("R10 old route kept", bad, 0);
    fill_tx(8);
    xfer(8, 1'b1, 1'b0, 32'h0);
    chk("R10 new route next transfer", {30'd0, last_lo_cs, last_up_cs}, 32'd2);
    bad = 0;
    for (int k = 0; k < 8; k++) if (dev_up.mem[k] !== tx[k][3:0]) bad++;
    chk("R10 upper written after", bad, 0);

    // R9: lower enables follow engine drive enable
    @(negedge clk);
    eng_oe = 1'b1;
    @(negedge clk);
    chk("R9 lower enables", {28'd0, lo_dq_oe}, 32'hF);
    eng_oe = 1'b0;
    @(negedge clk);
    chk("R9 lower enables off", {28'd0, lo_dq_oe}, 32'h0);

    finish_run();
  end
endmodule